// File: doc/BRIEF.md
# Carry-Save Up-Counter

This block is a synchronous up-counter whose state is kept in redundant carry-save form. Every bit position owns two flops: a sum bit and a stored carry bit. On an enabled cycle, each position half-adds its sum bit with one incoming term. Position 0 takes a constant one as that term. Every other position takes the stored carry of the position just below it. The carry that this produces is stored, and a later cycle absorbs it. No carry travels across the word within one cycle, so the register-to-register path has the same depth at any width.

A separate combinational adder turns the two vectors into an ordinary binary count. That adder only drives an output. It never feeds the next-state logic, so a consumer that needs the binary value pays the full-width carry delay, and the counter itself does not. The carry out of the top position is dropped, so the count wraps modulo 2^WIDTH. The width is a parameter and is intended for use at 16, 32 and 64 bits.

Top module: `csc_counter`

## Requirements
- R1: The state is held as two WIDTH-bit vectors, `sum_o` and `carry_o`. Bit i of each belongs to position i. Both vectors are outputs, and WIDTH is a parameter with a default of 16.
- R2: While `rst_ni` is low, every sum and carry bit is cleared to zero at once, without waiting for a clock edge, and `value_o` reads 0.
- R3: On a rising clock edge with `en_i` low, `sum_o` and `carry_o` keep their previous values.
- R4: On a rising clock edge with `en_i` high, position i takes an incoming term t. For i=0, t is 1; for i>0, t is the previous `carry_o[i-1]`. The new `sum_o[i]` becomes the previous `sum_o[i]` XOR t, and the new `carry_o[i]` becomes the previous `sum_o[i]` AND t.
- R5: `value_o` always equals `sum_o + (carry_o << 1)`, taken modulo 2^WIDTH. The carry of the top position does not contribute.
- R6: After K enabled edges since reset, `value_o` equals K modulo 2^WIDTH. After 2^WIDTH-1 the count returns to 0.
- R7: No position ever has both its sum bit and its carry bit set at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable; advance by one on this edge |
| sum_o | output | WIDTH | Stored sum bit of each position |
| carry_o | output | WIDTH | Stored carry bit of each position |
| value_o | output | WIDTH | Resolved binary count, modulo 2^WIDTH |

## Verification
The hardest behaviour to reach from the ports is the wrap from the all-ones count back to zero. Only a long run of enabled edges gets there, and during that run the stored carries have to keep reaching the top position, where they are dropped. The bench builds the counter at 16 bits and holds enable high for more than 2^16 consecutive edges, so it crosses the wrap. Randomly gated stretches come before and after that run, and an asynchronous reset is applied mid-run. A behavioural reference checks the count, the per-position state and the no-double-bit invariant on every clock.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int unsigned CSC_DEF_WIDTH = 16;

  typedef struct packed {
    logic sum;
    logic carry;
  } csc_pos_t;
endpackage

// File: rtl/csc_cell.sv
module csc_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic term_i,
  output csc_pkg::csc_pos_t pos_o
);
  csc_pkg::csc_pos_t pos_q;
  csc_pkg::csc_pos_t pos_d;

  // half-add of own sum with incoming term
  always_comb begin
    pos_d = pos_q;
    if (en_i) begin
      pos_d.sum   = pos_q.sum ^ term_i;
      pos_d.carry = pos_q.sum & term_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= pos_d;
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/csc_resolve.sv
module csc_resolve #(
  parameter int unsigned WIDTH = csc_pkg::CSC_DEF_WIDTH
) (
  input  logic [WIDTH-1:0] sum_i,
  input  logic [WIDTH-1:0] carry_i,
  output logic [WIDTH-1:0] value_o
);
  logic [WIDTH-1:0] carry_shl;

  // top carry falls off: count is modulo 2^WIDTH
  assign carry_shl = {carry_i[WIDTH-2:0], 1'b0};
  assign value_o   = sum_i + carry_shl;
endmodule

// File: rtl/csc_counter.sv
module csc_counter #(
  parameter int unsigned WIDTH = csc_pkg::CSC_DEF_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH-1:0] carry_o,
  output logic [WIDTH-1:0] value_o
);
  csc_pkg::csc_pos_t pos [WIDTH];
  logic [WIDTH-1:0]  term;

  for (genvar g = 0; g < WIDTH; g++) begin : g_pos
    if (g == 0) begin : g_lsb
      assign term[g] = 1'b1;
    end else begin : g_upper
      assign term[g] = pos[g-1].carry;
    end

    csc_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i),
      .term_i (term[g]),
      .pos_o  (pos[g])
    );

    assign sum_o[g]   = pos[g].sum;
    assign carry_o[g] = pos[g].carry;
  end

  // output-only resolver, not in the feedback loop
  csc_resolve #(.WIDTH(WIDTH)) u_resolve (
    .sum_i   (sum_o),
    .carry_i (carry_o),
    .value_o (value_o)
  );
endmodule

// File: rtl/csc_counter_chk.sv
module csc_counter_chk #(
  parameter int unsigned WIDTH = csc_pkg::CSC_DEF_WIDTH
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [WIDTH-1:0] sum_o,
  input logic [WIDTH-1:0] carry_o,
  input logic [WIDTH-1:0] value_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R2: assert (sum_o == '0 && carry_o == '0 && value_o == '0);
    end
  end

  assert_hold_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(sum_o) && $stable(carry_o)));

  assert_lsb_toggle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (sum_o[0] == !$past(sum_o[0]) && carry_o[0] == $past(sum_o[0])));

  assert_step_one_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (value_o == WIDTH'($past(value_o) + 1'b1)));

  assert_no_double_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_o & carry_o) == '0);
endmodule

bind csc_counter csc_counter_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/csc_counter_tb.sv
module csc_counter_tb_top;
  localparam int W = 16;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic en_i;
  logic [W-1:0] sum_o, carry_o, value_o;

  always #4 clk_i = ~clk_i;  // 125 MHz

  csc_counter #(.WIDTH(W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .sum_o(sum_o), .carry_o(carry_o), .value_o(value_o)
  );

  int checks = 0;
  int failures = 0;
  longint ref_k = 0;
  logic [W-1:0] ms = '0, mc = '0;
  logic [W-1:0] prev_s = '0, prev_c = '0;
  bit prev_en = 1'b0;
  bit seen_wrap = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void advance_model();
    logic [W-1:0] ns, nc;
    for (int i = 0; i < W; i++) begin
      bit t = (i == 0) ? 1'b1 : mc[i-1];
      ns[i] = ms[i] ^ t;
      nc[i] = ms[i] & t;
    end
    ms = ns;
    mc = nc;
    ref_k++;
  endfunction

  // at a falling edge: compare current outputs, then drive enable for next edge
  task automatic step(input bit en);
    logic [W-1:0] exp_val;
    @(negedge clk_i);
    exp_val = W'(ref_k);
    chk(value_o == exp_val, "R6 count", value_o, exp_val);
    chk(sum_o == ms && carry_o == mc, "R4 state", {sum_o, carry_o}, {ms, mc});
    chk(value_o == W'(sum_o + {carry_o[W-2:0], 1'b0}), "R5 resolve",
        value_o, W'(sum_o + {carry_o[W-2:0], 1'b0}));
    chk((sum_o & carry_o) == '0, "R7 exclusive", sum_o & carry_o, 0);
    if (!prev_en)
      chk(sum_o == prev_s && carry_o == prev_c, "R3 hold", {sum_o, carry_o}, {prev_s, prev_c});
    if (ref_k > 0 && exp_val == '0) seen_wrap = 1'b1;
    prev_s = sum_o;
    prev_c = carry_o;
    prev_en = en;
    en_i = en;
    if (en) advance_model();
  endtask

  task automatic check_reset_state(input string tag);
    chk(sum_o == '0 && carry_o == '0, tag, {sum_o, carry_o}, 0);
    chk(value_o == '0, tag, value_o, 0);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check_reset_state("R2 reset");  // R1: both vectors visible at ports
    rst_ni = 1'b1;
    prev_s = '0; prev_c = '0; prev_en = 1'b0;

    for (int n = 0; n < 300; n++) step(($urandom % 3) != 0);
    for (int n = 0; n < 20; n++) step(1'b0);
    for (int n = 0; n < 65600; n++) step(1'b1);
    chk(seen_wrap, "R6 wrap reached", seen_wrap, 1);
    for (int n = 0; n < 200; n++) step(($urandom % 2) != 0);

    // asynchronous reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check_reset_state("R2 async clear");
    ms = '0; mc = '0; ref_k = 0;
    prev_s = '0; prev_c = '0; prev_en = 1'b0;
    en_i = 1'b1;
    @(negedge clk_i);
    check_reset_state("R2 held in reset");
    rst_ni = 1'b1;
    en_i = 1'b0;
    for (int n = 0; n < 400; n++) step(($urandom % 4) != 0);
    step(1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule